// File: doc/BRIEF.md
# Waveform Timer Channel

A single 16-bit timer channel that generates two digital waveforms, `out_a` and `out_b`. A counter advances on a prescaled count-enable tick. It can count upward, or upward and then downward. In either form the top of the count can be bounded by a third compare value, called C. Three compare registers (A, B, C) are matched against the counter. Two further event sources also act on the channel: an external event, taken on a selectable edge of a selectable input, and a software trigger. For each output, every event carries its own two-bit action: no-op, set, clear or toggle.

The channel is set up through a small write-only register port. One configuration word holds the counting mode, the eight output actions, the external event source and edge, the trigger enable and the two C-compare stop options. The compare values and the interrupt enables each have a register of their own. Five sticky status flags record overflow, the three compares and the external event. Reading the status clears them. `irq` is the OR of the flags whose enable bit is set. The external inputs are assumed to be synchronous to `clk`.

Top module: `wave_timer_channel`

## Requirements
- R1: After reset the count is 0, both outputs are 0, all status flags and `irq` are 0, the counter is not running, and every configuration register reads as 0.
- R2: The counter advances only in a cycle with `running` and `cnt_en` both high. In mode 0 (up) it adds one per tick and wraps from 0xFFFF to 0. A tick taken at 0xFFFF while counting up sets the overflow flag, status bit 0.
- R3: In mode 1 (up with C trigger), a tick taken at count == C loads 0 instead of incrementing. A, B and C compare events fire on a tick taken while the count equals the value of the matching register, and set status bits 1, 2 and 3.
- R4: In mode 2 (up/down), counting reverses at 0xFFFF and again at 0. In mode 3 (up/down with C trigger), counting also reverses at a non-zero C while counting up.
- R5: Configuration word (address 0), action fields in pairs of bits, with the encoding 0 = no-op, 1 = set, 2 = clear, 3 = toggle. For A: compare A at [3:2], compare C at [5:4], external event at [7:6], software trigger at [9:8]. For B: compare B at [11:10], compare C at [13:12], external event at [15:14], software trigger at [17:16]. The mode is at [1:0].
- R6: When several events with a non-no-op action hit one output in the same cycle, only the highest applies. The order, from highest down, is software trigger, external event, C compare, own compare (A or B).
- R7: External source select at [19:18]: 0 = `ext_bin`, 1 to 3 = `ext_clk[0]` to `ext_clk[2]`. Edge select at [21:20]: 0 = none, 1 = rising, 2 = falling, 3 = both. A detected edge sets status bit 4.
- R8: With bit 22 set, a detected external event resets the count to 0 and sets the direction to up, like a trigger.
- R9: `sw_trig` resets the count to 0, sets the direction to up and restarts a counter halted by a C-compare stop. A trigger cycle takes no tick and produces no compare or overflow event.
- R10: With bit 23 set, a C compare halts counting until the next trigger or `start_cmd`. With bit 24 set, a C compare disables counting, and only `start_cmd` re-enables it; triggers do not.
- R11: Status flags are sticky. A cycle with `sts_rd` high clears them, but events in that same cycle still set their bits. `irq` is high exactly when a flag and its enable bit (address 4, bits [4:0]) are both set.
- R12: `stop_cmd` disables counting from the next cycle and takes precedence over `start_cmd`. Register addresses: 1 = A, 2 = B, 3 = C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Prescaled count tick |
| start_cmd | input | 1 | Enable and un-halt the counter |
| stop_cmd | input | 1 | Disable the counter |
| sw_trig | input | 1 | Software trigger |
| ext_bin | input | 1 | B-side external input, event source 0 |
| ext_clk | input | 3 | External clock lines, event sources 1 to 3 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 25 | Register write data |
| sts_rd | input | 1 | Status read, clears the flags |
| count | output | 16 | Counter value |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| status | output | 5 | Flags: overflow, A, B, C compare, external event |
| irq | output | 1 | Interrupt request |
| running | output | 1 | Counter enabled and not halted |

## Verification
Every result is registered once. A tick, trigger, event, command or register write sampled at a rising edge shows on `count`, `out_a`, `out_b`, `status` and `running` right after that edge. `irq` follows the flags within the same cycle. The bench drives inputs on the falling edge and advances its model by exactly one step for that edge. It then compares every output at the next falling edge, so each comparison lands one cycle after its stimulus. External edges are seen against the value held on the previous edge, so a level change counts as an event at the first edge that samples it.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int CFG_BITS  = 25;
  localparam int NUM_FLAGS = 5;
  localparam int FL_OVF = 0;
  localparam int FL_CPA = 1;
  localparam int FL_CPB = 2;
  localparam int FL_CPC = 3;
  localparam int FL_EXT = 4;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    MODE_UP         = 2'd0,
    MODE_UP_CTRIG   = 2'd1,
    MODE_UPDN       = 2'd2,
    MODE_UPDN_CTRIG = 2'd3
  } cmode_e;

  typedef enum logic [2:0] {
    REG_CFG = 3'd0,
    REG_RA  = 3'd1,
    REG_RB  = 3'd2,
    REG_RC  = 3'd3,
    REG_IER = 3'd4
  } regsel_e;

  typedef struct packed {
    logic       c_disable;    // 24
    logic       c_stop;       // 23
    logic       ext_trig_en;  // 22
    logic [1:0] ext_edge_sel; // 21:20
    logic [1:0] ext_src;      // 19:18
    act_e       b_sw;         // 17:16
    act_e       b_ext;        // 15:14
    act_e       b_cc;         // 13:12
    act_e       b_cmp;        // 11:10
    act_e       a_sw;         // 9:8
    act_e       a_ext;        // 7:6
    act_e       a_cc;         // 5:4
    act_e       a_cmp;        // 3:2
    cmode_e     mode;         // 1:0
  } wave_cfg_t;

  function automatic logic apply_action(input logic cur, input act_e a);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic edge_hit(input logic now, input logic was, input logic [1:0] sel);
    case (sel)
      2'd1:    return now & ~was;
      2'd2:    return ~now & was;
      2'd3:    return now ^ was;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_updown(input cmode_e m);
    return (m == MODE_UPDN) || (m == MODE_UPDN_CTRIG);
  endfunction
endpackage

// File: rtl/wtc_ext_event.sv
module wtc_ext_event #(
  parameter int NSRC  = 4,
  parameter int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       edge_sel_i,
  output logic             ev_o
);
  import wtc_pkg::*;

  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  assign ev_o = edge_hit(src_i[sel_i], prev_q[sel_i], edge_sel_i);

  AST_EVENT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o |=> (prev_q[$past(sel_i)] != $past(prev_q[sel_i]))) else $error("ext event without change"); // R7
endmodule

// File: rtl/wtc_counter.sv
module wtc_counter #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            trig_i,
  input  wtc_pkg::cmode_e mode_i,
  input  logic [W-1:0]    ra_i,
  input  logic [W-1:0]    rb_i,
  input  logic [W-1:0]    rc_i,
  output logic [W-1:0]    cnt_o,
  output logic            cpa_o,
  output logic            cpb_o,
  output logic            cpc_o,
  output logic            ovf_o
);
  import wtc_pkg::*;

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;
  logic         at_top;

  assign at_top = (cnt_q == MAXV) ||
                  (mode_i == MODE_UPDN_CTRIG && cnt_q == rc_i && cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (trig_i) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (tick_i) begin
      case (mode_i)
        MODE_UP: begin
          cnt_d = cnt_q + ONE;
          up_d  = 1'b1;
        end
        MODE_UP_CTRIG: begin
          cnt_d = (cnt_q == rc_i) ? '0 : cnt_q + ONE;
          up_d  = 1'b1;
        end
        default: begin
          if (up_q) begin
            if (at_top) begin
              up_d  = 1'b0;
              cnt_d = cnt_q - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              up_d  = 1'b1;
              cnt_d = ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cpa_o = tick_i && (cnt_q == ra_i);
  assign cpb_o = tick_i && (cnt_q == rb_i);
  assign cpc_o = tick_i && (cnt_q == rc_i);
  assign ovf_o = tick_i && (cnt_q == MAXV) && (up_q || !is_updown(mode_i));

  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (cnt_q == '0) && up_q) else $error("trigger did not clear count"); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !trig_i) |=> $stable(cnt_q)) else $error("count moved without tick"); // R2
  AST_TURN_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && is_updown(mode_i) && up_q && cnt_q == MAXV) |=> (!up_q && cnt_q == MAXV - ONE))
    else $error("no reversal at full scale"); // R4
endmodule

// File: rtl/wtc_out_ctrl.sv
module wtc_out_ctrl (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_sw_i,
  input  logic          ev_ext_i,
  input  logic          ev_cc_i,
  input  logic          ev_cmp_i,
  input  wtc_pkg::act_e act_sw_i,
  input  wtc_pkg::act_e act_ext_i,
  input  wtc_pkg::act_e act_cc_i,
  input  wtc_pkg::act_e act_cmp_i,
  output logic          out_o
);
  import wtc_pkg::*;

  logic out_q;
  act_e win_act;

  always_comb begin
    win_act = ACT_NONE;
    if      (ev_sw_i  && act_sw_i  != ACT_NONE) win_act = act_sw_i;
    else if (ev_ext_i && act_ext_i != ACT_NONE) win_act = act_ext_i;
    else if (ev_cc_i  && act_cc_i  != ACT_NONE) win_act = act_cc_i;
    else if (ev_cmp_i && act_cmp_i != ACT_NONE) win_act = act_cmp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= apply_action(out_q, win_act);
  end

  assign out_o = out_q;

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_sw_i || ev_ext_i || ev_cc_i || ev_cmp_i) |=> $stable(out_o)) else $error("output moved without event"); // R5
  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sw_i && act_sw_i == ACT_SET) |=> out_o) else $error("software action lost"); // R6
endmodule

// File: rtl/wtc_status.sv
module wtc_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic         rd_i,
  input  logic [N-1:0] ier_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= '0;
    else if (rd_i) flags_q <= ev_i;
    else           flags_q <= flags_q | ev_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & ier_i);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && ev_i == '0) |=> (flags_o == '0)) else $error("read did not clear"); // R11
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))) else $error("flag lost without read"); // R11
endmodule

// File: rtl/wave_timer_channel.sv
module wave_timer_channel #(
  parameter int CNT_W    = 16,
  parameter int NUM_XCLK = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cnt_en,
  input  logic                         start_cmd,
  input  logic                         stop_cmd,
  input  logic                         sw_trig,
  input  logic                         ext_bin,
  input  logic [NUM_XCLK-1:0]          ext_clk,
  input  logic                         cfg_we,
  input  logic [2:0]                   cfg_addr,
  input  logic [wtc_pkg::CFG_BITS-1:0] cfg_wdata,
  input  logic                         sts_rd,
  output logic [CNT_W-1:0]             count,
  output logic                         out_a,
  output logic                         out_b,
  output logic [wtc_pkg::NUM_FLAGS-1:0] status,
  output logic                         irq,
  output logic                         running
);
  import wtc_pkg::*;

  localparam int NSRC  = NUM_XCLK + 1;
  localparam int SEL_W = $clog2(NSRC);
  localparam int NOUT  = 2;

  wave_cfg_t            cfg_q;
  logic [CNT_W-1:0]     ra_q, rb_q, rc_q;
  logic [NUM_FLAGS-1:0] ier_q;
  logic                 en_q, halt_q;

  // named internal events
  logic ext_ev, trig, tick;
  logic cpa_ev, cpb_ev, cpc_ev, ovf_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ra_q  <= '0;
      rb_q  <= '0;
      rc_q  <= '0;
      ier_q <= '0;
    end else if (cfg_we) begin
      case (regsel_e'(cfg_addr))
        REG_CFG: cfg_q <= wave_cfg_t'(cfg_wdata);
        REG_RA:  ra_q  <= cfg_wdata[CNT_W-1:0];
        REG_RB:  rb_q  <= cfg_wdata[CNT_W-1:0];
        REG_RC:  rc_q  <= cfg_wdata[CNT_W-1:0];
        REG_IER: ier_q <= cfg_wdata[NUM_FLAGS-1:0];
        default: ;
      endcase
    end
  end

  wtc_ext_event #(.NSRC(NSRC), .SEL_W(SEL_W)) u_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      ({ext_clk, ext_bin}),
    .sel_i      (cfg_q.ext_src),
    .edge_sel_i (cfg_q.ext_edge_sel),
    .ev_o       (ext_ev)
  );

  assign running = en_q & ~halt_q;
  assign trig    = sw_trig | (ext_ev & cfg_q.ext_trig_en);
  assign tick    = running & cnt_en & ~trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (stop_cmd)                          en_q <= 1'b0;
      else if (start_cmd)                    en_q <= 1'b1;
      else if (cpc_ev && cfg_q.c_disable)    en_q <= 1'b0;
      if (trig || start_cmd)                 halt_q <= 1'b0;
      else if (cpc_ev && cfg_q.c_stop)       halt_q <= 1'b1;
    end
  end

  wtc_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .trig_i (trig),
    .mode_i (cfg_q.mode),
    .ra_i   (ra_q),
    .rb_i   (rb_q),
    .rc_i   (rc_q),
    .cnt_o  (count),
    .cpa_o  (cpa_ev),
    .cpb_o  (cpb_ev),
    .cpc_o  (cpc_ev),
    .ovf_o  (ovf_ev)
  );

  // per-output event and action vectors: index 0 = A, 1 = B
  logic [NOUT-1:0] own_cmp_v;
  act_e            act_sw_v  [NOUT];
  act_e            act_ext_v [NOUT];
  act_e            act_cc_v  [NOUT];
  act_e            act_cmp_v [NOUT];
  logic [NOUT-1:0] out_v;

  assign own_cmp_v    = {cpb_ev, cpa_ev};
  assign act_sw_v[0]  = cfg_q.a_sw;
  assign act_ext_v[0] = cfg_q.a_ext;
  assign act_cc_v[0]  = cfg_q.a_cc;
  assign act_cmp_v[0] = cfg_q.a_cmp;
  assign act_sw_v[1]  = cfg_q.b_sw;
  assign act_ext_v[1] = cfg_q.b_ext;
  assign act_cc_v[1]  = cfg_q.b_cc;
  assign act_cmp_v[1] = cfg_q.b_cmp;

  for (genvar gi = 0; gi < NOUT; gi++) begin : g_out
    wtc_out_ctrl u_oc (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_sw_i   (sw_trig),
      .ev_ext_i  (ext_ev),
      .ev_cc_i   (cpc_ev),
      .ev_cmp_i  (own_cmp_v[gi]),
      .act_sw_i  (act_sw_v[gi]),
      .act_ext_i (act_ext_v[gi]),
      .act_cc_i  (act_cc_v[gi]),
      .act_cmp_i (act_cmp_v[gi]),
      .out_o     (out_v[gi])
    );
  end

  assign out_a = out_v[0];
  assign out_b = out_v[1];

  logic [NUM_FLAGS-1:0] flag_ev;
  always_comb begin
    flag_ev         = '0;
    flag_ev[FL_OVF] = ovf_ev;
    flag_ev[FL_CPA] = cpa_ev;
    flag_ev[FL_CPB] = cpb_ev;
    flag_ev[FL_CPC] = cpc_ev;
    flag_ev[FL_EXT] = ext_ev;
  end

  wtc_status #(.N(NUM_FLAGS)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (flag_ev),
    .rd_i    (sts_rd),
    .ier_i   (ier_q),
    .flags_o (status),
    .irq_o   (irq)
  );

  AST_DISABLED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !start_cmd) |=> !en_q) else $error("enabled without start"); // R10
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !running) else $error("still running after stop"); // R12
endmodule

// File: tb/test_wave_timer_channel.sv
module test_wave_timer_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 0, start_cmd = 0, stop_cmd = 0, sw_trig = 0, ext_bin = 0;
  logic [2:0]  ext_clk = '0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = '0;
  logic [24:0] cfg_wdata = '0;
  logic        sts_rd = 0;
  logic [15:0] count;
  logic        out_a, out_b, irq, running;
  logic [4:0]  status;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wave_timer_channel i_wave_timer_channel (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .sw_trig(sw_trig), .ext_bin(ext_bin), .ext_clk(ext_clk), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sts_rd(sts_rd), .count(count),
    .out_a(out_a), .out_b(out_b), .status(status), .irq(irq), .running(running)
  );

  // reference state
  logic [15:0] m_cnt = 0, m_ra = 0, m_rb = 0, m_rc = 0;
  logic        m_up = 1, m_a = 0, m_b = 0, m_en = 0, m_halt = 0;
  logic [4:0]  m_fl = 0, m_ier = 0;
  logic [3:0]  m_prev = 0;
  logic [24:0] m_cfg = 0;

  function automatic logic do_act(logic v, logic [1:0] code);
    if (code == 2'd1) return 1'b1;
    if (code == 2'd2) return 1'b0;
    if (code == 2'd3) return !v;
    return v;
  endfunction

  // events listed lowest to highest priority; the last active non-no-op one wins
  function automatic logic resolve(logic v, logic [3:0] evs, logic [7:0] acts);
    logic [1:0] pick = 2'd0;
    for (int k = 0; k < 4; k++)
      if (evs[k] && acts[2*k +: 2] != 2'd0) pick = acts[2*k +: 2];
    return do_act(v, pick);
  endfunction

  function automatic logic [24:0] mkcfg(logic [1:0] mode, logic [7:0] acts_a, logic [7:0] acts_b,
                                        logic [1:0] src, logic [1:0] edg, logic ten, logic cst, logic cdi);
    return {cdi, cst, ten, edg, src, acts_b, acts_a, mode};
  endfunction

  task automatic model_step();
    logic [3:0] srcs = {ext_clk, ext_bin};
    logic [1:0] sel = m_cfg[19:18], edg = m_cfg[21:20], mode = m_cfg[1:0];
    logic cur = srcs[sel], pv = m_prev[sel];
    logic ext = (edg == 2'd1 && cur && !pv) || (edg == 2'd2 && !cur && pv) || (edg == 2'd3 && cur != pv);
    logic trg = sw_trig || (ext && m_cfg[22]);
    logic tk = m_en && !m_halt && cnt_en && !trg;
    logic ca = tk && m_cnt == m_ra, cb = tk && m_cnt == m_rb, cc = tk && m_cnt == m_rc;
    logic ov = tk && m_cnt == 16'hFFFF && (mode < 2 || m_up);
    logic top;
    m_a = resolve(m_a, {sw_trig, ext, cc, ca}, {m_cfg[9:8], m_cfg[7:6], m_cfg[5:4], m_cfg[3:2]});
    m_b = resolve(m_b, {sw_trig, ext, cc, cb}, {m_cfg[17:16], m_cfg[15:14], m_cfg[13:12], m_cfg[11:10]});
    if (trg) begin m_cnt = 0; m_up = 1; end
    else if (tk) begin
      if (mode == 0) begin m_cnt = m_cnt + 1; m_up = 1; end
      else if (mode == 1) begin m_cnt = (m_cnt == m_rc) ? 16'd0 : m_cnt + 1; m_up = 1; end
      else begin
        top = (m_cnt == 16'hFFFF) || (mode == 3 && m_cnt == m_rc && m_cnt != 0);
        if (m_up) begin
          if (top) begin m_up = 0; m_cnt = m_cnt - 1; end else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end else m_cnt = m_cnt - 1;
        end
      end
    end
    if (sts_rd) m_fl = 0;
    m_fl = m_fl | {ext, cc, cb, ca, ov};
    if (stop_cmd) m_en = 0; else if (start_cmd) m_en = 1; else if (cc && m_cfg[24]) m_en = 0;
    if (trg || start_cmd) m_halt = 0; else if (cc && m_cfg[23]) m_halt = 1;
    m_prev = srcs;
    if (cfg_we) begin
      case (cfg_addr)
        3'd0: m_cfg = cfg_wdata;
        3'd1: m_ra = cfg_wdata[15:0];
        3'd2: m_rb = cfg_wdata[15:0];
        3'd3: m_rc = cfg_wdata[15:0];
        3'd4: m_ier = cfg_wdata[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic cmp(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag, "count", count, m_cnt);
    cmp(tag, "out_a", out_a, m_a);
    cmp(tag, "out_b", out_b, m_b);
    cmp(tag, "status", status, m_fl);
    cmp(tag, "irq", irq, |(m_fl & m_ier));
    cmp(tag, "running", running, m_en && !m_halt);
  endtask

  task automatic step(string tag);
    model_step();
    @(negedge clk);
    check_all(tag);
    sw_trig = 0; start_cmd = 0; stop_cmd = 0; cfg_we = 0; sts_rd = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [24:0] d, string tag);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R2: up mode, full wrap with overflow, stop command R12
    wr(3'd4, 25'h1F, "R11");
    wr(3'd1, 25'd3, "R3");
    wr(3'd2, 25'd10, "R3");
    wr(3'd0, mkcfg(2'd0, 8'b0000_0011, 8'b0000_0001, 2'd0, 2'd0, 0, 0, 0), "R5");
    start_cmd = 1; step("R2");
    cnt_en = 1; run(6, "R2");
    stop_cmd = 1; step("R12");
    run(4, "R12");
    start_cmd = 1; stop_cmd = 1; step("R12");
    start_cmd = 1; step("R2");
    run(65540, "R2");
    sts_rd = 1; step("R11");

    // R4: up/down reversing at full scale, then at C
    wr(3'd0, mkcfg(2'd2, 8'h00, 8'h00, 2'd0, 2'd0, 0, 0, 0), "R4");
    run(65545, "R4");
    wr(3'd3, 25'd6, "R4");
    wr(3'd0, mkcfg(2'd3, 8'b0000_0011, 8'b0011_0000, 2'd0, 2'd0, 0, 0, 0), "R4");
    sw_trig = 1; step("R9");
    run(30, "R4");

    // R3 / R5: up with C trigger and per-event actions
    wr(3'd3, 25'd5, "R3");
    wr(3'd1, 25'd2, "R3");
    wr(3'd2, 25'd4, "R3");
    wr(3'd0, mkcfg(2'd1, 8'b0000_1001, 8'b0000_0011, 2'd0, 2'd0, 0, 0, 0), "R5");
    run(20, "R3");

    // R6: A compare and C compare collide, C action wins; then software beats external
    wr(3'd1, 25'd5, "R6");
    wr(3'd0, mkcfg(2'd1, 8'b0110_1001, 8'b0100_0000, 2'd0, 2'd1, 0, 0, 0), "R6");
    run(12, "R6");
    ext_bin = 1; sw_trig = 1; step("R6");
    ext_bin = 0; step("R6");

    // R7 / R8: external clock line 1, falling edge, then as a trigger
    wr(3'd0, mkcfg(2'd0, 8'b1100_0000, 8'b1101_0000, 2'd2, 2'd2, 0, 0, 0), "R7");
    ext_clk[0] = 1; step("R7");
    ext_clk[0] = 0; step("R7");
    ext_clk[1] = 1; step("R7");
    ext_clk[1] = 0; step("R7");
    run(3, "R7");
    wr(3'd0, mkcfg(2'd0, 8'b1100_0000, 8'h00, 2'd2, 2'd3, 1, 0, 0), "R8");
    ext_clk[1] = 1; step("R8");
    run(3, "R8");
    ext_clk[1] = 0; step("R8");
    run(3, "R8");

    // R9: software trigger mid count
    sw_trig = 1; step("R9");
    run(4, "R9");

    // R10: stop on C, trigger resumes; disable on C, only start resumes
    wr(3'd3, 25'd4, "R10");
    wr(3'd0, mkcfg(2'd1, 8'h00, 8'h00, 2'd0, 2'd0, 0, 1, 0), "R10");
    run(10, "R10");
    sw_trig = 1; step("R10");
    run(8, "R10");
    wr(3'd0, mkcfg(2'd1, 8'h00, 8'h00, 2'd0, 2'd0, 0, 0, 1), "R10");
    run(10, "R10");
    sw_trig = 1; step("R10");
    run(4, "R10");
    start_cmd = 1; step("R10");
    run(4, "R10");

    // R11: read-clear, enables gating irq
    wr(3'd4, 25'h04, "R11");
    sts_rd = 1; step("R11");
    run(6, "R11");
    wr(3'd4, 25'h00, "R11");
    step("R11");

    // random mix: R5 R6 R7 R10 R11
    for (int i = 0; i < 15000; i++) begin
      cnt_en    = ($urandom % 4) != 0;
      sw_trig   = ($urandom % 32) == 0;
      start_cmd = ($urandom % 20) == 0;
      stop_cmd  = ($urandom % 50) == 0;
      sts_rd    = ($urandom % 10) == 0;
      if (($urandom % 5) == 0) ext_bin = $urandom;
      if (($urandom % 5) == 0) ext_clk = $urandom;
      if (($urandom % 40) == 0) begin
        cfg_we = 1;
        cfg_addr = $urandom % 5;
        if (cfg_addr == 3'd0) cfg_wdata = $urandom;
        else if (cfg_addr == 3'd4) cfg_wdata = $urandom % 32;
        else cfg_wdata = 1 + ($urandom % 40);
      end
      step("R5 R6 R7 R10 R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule